// File: doc/BRIEF.md
# Byte Mailbox Port for Indirect Register Access

This block lets a host reach a small internal register file through only two byte-wide I/O locations. One location carries data in both directions. The other location returns a status byte when read and accepts a command byte when written. To read a register, the host writes the read command and then the register index. It then waits for the output-ready flag and takes the result from the data location. To write a register, the host writes the write command, then the index, then the value.

Every byte the host writes is held in an input latch. An input-busy flag stays raised while the internal sequencer takes that byte, which lasts a fixed number of clock cycles set by a parameter. Before each byte, the host polls the status byte until the busy flag is low. Writes that arrive while the flag is high are lost. Register accesses leave the block as single-cycle read and write strobes with an index. The read data returns combinationally in the same cycle as the read strobe.

Top module: `mbx_port`

## Requirements
- R1: After reset, the status byte reads 0x00, the data location reads 0x00, and neither register strobe is active.
- R2: Host address 0 is the data location. Host address 4 is the status location on reads and the command location on writes. In the status byte, bit 0 is output-ready, bit 1 is input-busy and bit 3 is the command flag. All other status bits read 0.
- R3: Any host write taken while input-busy is low raises input-busy at that clock edge. Input-busy then falls exactly CONSUME_DLY clock edges later. A host write made while input-busy is high is dropped and leaves the held byte unchanged.
- R4: A taken write to the command location sets the command flag. A taken write to the data location clears it.
- R5: After command 0x80, the next data byte is used as an index. When that byte is consumed, the block issues one read strobe with that index. It loads the returned byte into the data location and sets output-ready on the same edge.
- R6: Output-ready clears when the host reads the data location. Reading the status location leaves it set.
- R7: After command 0x81, the next data byte is the index and the following data byte is the value. When the value is consumed, the block issues one write strobe carrying both.
- R8: A data byte consumed while no command is pending produces no register strobe.
- R9: A new command byte abandons any unfinished sequence. The bytes of the abandoned sequence cause no strobe.
- R10: A command byte other than 0x80 or 0x81 returns the sequencer to idle, so the data bytes that follow produce no strobe.
- R11: The read and write strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HOST_AW | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational on host_addr) |
| reg_rd | output | 1 | Internal register read strobe |
| reg_wr | output | 1 | Internal register write strobe |
| reg_index | output | REG_AW | Internal register index |
| reg_wdata | output | 8 | Internal register write data |
| reg_rdata | input | 8 | Internal register read data, valid with reg_rd |

## Verification
A sequencer stuck in the wrong state shows up first as a missing or extra register strobe. The bench counts strobes, so this is caught by the end of the sequence it spoils. The register contents read back on a later read expose the same fault. A wrong consume counter shows up as input-busy staying high for the wrong number of cycles after a single write, which is measured directly. A wrong output latch or flag shows in the status byte or the data location within one cycle of the consuming edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int BYTE_W      = 8;
   localparam int ST_OBF_BIT  = 0;
   localparam int ST_IBF_BIT  = 1;
   localparam int ST_CMD_BIT  = 3;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_RD_IDX,
      SQ_WR_IDX,
      SQ_WR_VAL
   } seq_state_t;

   typedef struct packed {
      logic              is_cmd;
      logic [BYTE_W-1:0] val;
   } in_byte_t;
endpackage

// File: rtl/mbx_bus_decode.sv
module mbx_bus_decode
   import mbx_pkg::*;
#(
   parameter int HOST_AW  = 3,
   parameter int DATA_OFS = 0,
   parameter int CTL_OFS  = 4
) (
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic               obf,
   input  logic               ibf,
   input  logic               cmd_flag,
   input  logic [BYTE_W-1:0]  out_byte,
   output logic               wr_data,
   output logic               wr_ctl,
   output logic               rd_data_port,
   output logic [BYTE_W-1:0]  host_rdata
);
   localparam logic [HOST_AW-1:0] DATA_A = HOST_AW'(DATA_OFS);
   localparam logic [HOST_AW-1:0] CTL_A  = HOST_AW'(CTL_OFS);

   logic [BYTE_W-1:0] status;

   always_comb begin
      status             = '0;
      status[ST_OBF_BIT] = obf;
      status[ST_IBF_BIT] = ibf;
      status[ST_CMD_BIT] = cmd_flag;
   end

   assign wr_data      = host_wr && (host_addr == DATA_A);
   assign wr_ctl       = host_wr && (host_addr == CTL_A);
   assign rd_data_port = host_rd && (host_addr == DATA_A);

   always_comb begin
      if (host_addr == DATA_A)     host_rdata = out_byte;
      else if (host_addr == CTL_A) host_rdata = status;
      else                         host_rdata = '0;
   end
endmodule

// File: rtl/mbx_in_latch.sv
module mbx_in_latch
   import mbx_pkg::*;
#(
   parameter int CONSUME_DLY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data,
   input  logic              wr_ctl,
   input  logic [BYTE_W-1:0] wdata,
   output logic              ibf,
   output logic              cmd_flag,
   output logic              consume,
   output in_byte_t          held
);
   logic accept;
   assign accept = (wr_data || wr_ctl) && !ibf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ibf      <= 1'b0;
         cmd_flag <= 1'b0;
         held     <= '0;
      end else if (accept) begin
         ibf         <= 1'b1;
         cmd_flag    <= wr_ctl;
         held.is_cmd <= wr_ctl;
         held.val    <= wdata;
      end else if (consume) begin
         ibf <= 1'b0;
      end
   end

   generate
      if (CONSUME_DLY == 1) begin : g_no_cnt
         assign consume = ibf;
      end else begin : g_cnt
         localparam int CW = $clog2(CONSUME_DLY);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)              cnt <= '0;
            else if (accept)         cnt <= CW'(CONSUME_DLY - 1);
            else if (ibf && cnt != 0) cnt <= cnt - 1'b1;
         end
         assign consume = ibf && (cnt == 0);
      end
   endgenerate

   assert_ibf_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ibf) |-> $past(wr_data || wr_ctl));
   assert_busy_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ibf && !consume && (wr_data || wr_ctl)) |=> ($stable(held) && ibf));
   assert_cmd_flag_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_flag) |-> $past(wr_ctl));
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
   import mbx_pkg::*;
#(
   parameter int                REG_AW = 4,
   parameter logic [BYTE_W-1:0] CMD_RD = 8'h80,
   parameter logic [BYTE_W-1:0] CMD_WR = 8'h81
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              consume,
   input  in_byte_t          held,
   input  logic              rd_data_port,
   input  logic [BYTE_W-1:0] reg_rdata,
   output logic              reg_rd,
   output logic              reg_wr,
   output logic [REG_AW-1:0] reg_index,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              obf,
   output logic [BYTE_W-1:0] out_byte
);
   seq_state_t        state;
   logic [REG_AW-1:0] idx_q;
   logic              data_in;

   assign data_in   = consume && !held.is_cmd;
   assign reg_rd    = data_in && (state == SQ_RD_IDX);
   assign reg_wr    = data_in && (state == SQ_WR_VAL);
   assign reg_index = (state == SQ_RD_IDX) ? held.val[REG_AW-1:0] : idx_q;
   assign reg_wdata = held.val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         idx_q <= '0;
      end else if (consume && held.is_cmd) begin
         if (held.val == CMD_RD)      state <= SQ_RD_IDX;
         else if (held.val == CMD_WR) state <= SQ_WR_IDX;
         else                         state <= SQ_IDLE;
      end else if (data_in) begin
         case (state)
            SQ_WR_IDX: begin
               idx_q <= held.val[REG_AW-1:0];
               state <= SQ_WR_VAL;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         obf      <= 1'b0;
         out_byte <= '0;
      end else if (reg_rd) begin
         obf      <= 1'b1;
         out_byte <= reg_rdata;
      end else if (rd_data_port) begin
         obf <= 1'b0;
      end
   end

   assert_read_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> (obf && out_byte == $past(reg_rdata)));
   assert_obf_clear_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(obf) |-> $past(rd_data_port));
   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_wr));
endmodule

// File: rtl/mbx_port.sv
module mbx_port
   import mbx_pkg::*;
#(
   parameter int                HOST_AW     = 3,
   parameter int                DATA_OFS    = 0,
   parameter int                CTL_OFS     = 4,
   parameter int                REG_AW      = 4,
   parameter int                CONSUME_DLY = 3,
   parameter logic [7:0]        CMD_RD      = 8'h80,
   parameter logic [7:0]        CMD_WR      = 8'h81
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [7:0]         host_wdata,
   output logic [7:0]         host_rdata,
   output logic               reg_rd,
   output logic               reg_wr,
   output logic [REG_AW-1:0]  reg_index,
   output logic [7:0]         reg_wdata,
   input  logic [7:0]         reg_rdata
);
   generate
      if (CONSUME_DLY < 1) begin : g_bad_dly
         $error("CONSUME_DLY must be at least 1");
      end
      if (REG_AW < 1 || REG_AW > BYTE_W) begin : g_bad_aw
         $error("REG_AW must lie in 1..8");
      end
      if (DATA_OFS == CTL_OFS || CTL_OFS >= (1 << HOST_AW)) begin : g_bad_ofs
         $error("port offsets must differ and fit HOST_AW");
      end
   endgenerate

   logic     wr_data, wr_ctl, rd_data_port;
   logic     ibf, cmd_flag, consume, obf;
   in_byte_t held;
   logic [BYTE_W-1:0] out_byte;

   mbx_bus_decode #(.HOST_AW(HOST_AW), .DATA_OFS(DATA_OFS), .CTL_OFS(CTL_OFS)) u_dec (
      .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
      .obf(obf), .ibf(ibf), .cmd_flag(cmd_flag), .out_byte(out_byte),
      .wr_data(wr_data), .wr_ctl(wr_ctl), .rd_data_port(rd_data_port),
      .host_rdata(host_rdata));

   mbx_in_latch #(.CONSUME_DLY(CONSUME_DLY)) u_in (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_ctl(wr_ctl),
      .wdata(host_wdata), .ibf(ibf), .cmd_flag(cmd_flag),
      .consume(consume), .held(held));

   mbx_seq #(.REG_AW(REG_AW), .CMD_RD(CMD_RD), .CMD_WR(CMD_WR)) u_seq (
      .clk(clk), .rst_n(rst_n), .consume(consume), .held(held),
      .rd_data_port(rd_data_port), .reg_rdata(reg_rdata),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_index(reg_index),
      .reg_wdata(reg_wdata), .obf(obf), .out_byte(out_byte));

   assert_consume_needs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd || reg_wr) |-> ibf);
endmodule

// File: tb/mbx_port_test.sv
`timescale 1ns/1ps
module mbx_port_test;
   localparam int AW = 4;
   localparam int DLY = 3;
   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_CTL  = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] host_addr = '0;
   logic host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic reg_rd, reg_wr;
   logic [AW-1:0] reg_index;
   logic [7:0] reg_wdata, reg_rdata;

   logic [7:0] regfile [1<<AW];
   logic [7:0] shadow  [1<<AW];
   int checks = 0, errors = 0, rd_cnt = 0, wr_cnt = 0, both_cnt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   mbx_port #(.REG_AW(AW), .CONSUME_DLY(DLY)) uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_index(reg_index),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   assign reg_rdata = regfile[reg_index];

   function automatic logic [7:0] init_val(int i);
      return 8'(i * 7 + 3);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         if (reg_wr) regfile[reg_index] <= reg_wdata;
         if (reg_rd) rd_cnt++;
         if (reg_wr) wr_cnt++;
         if (reg_rd && reg_wr) both_cnt++;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic get_status(output logic [7:0] s);
      host_addr = A_CTL;
      #1;
      s = host_rdata;
   endtask

   task automatic host_write(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(posedge clk); #1;
      host_wr = 1'b0;
   endtask

   task automatic host_read(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(posedge clk); #1;
      host_rd = 1'b0;
   endtask

   task automatic wait_ibf();
      logic [7:0] s;
      get_status(s);
      for (int i = 0; i < 100 && s[1]; i++) begin
         @(posedge clk); #1;
         get_status(s);
      end
   endtask

   task automatic seq_write(logic [7:0] idx, logic [7:0] val);
      wait_ibf(); host_write(A_CTL, 8'h81);
      wait_ibf(); host_write(A_DATA, idx);
      wait_ibf(); host_write(A_DATA, val);
      wait_ibf();
      shadow[idx[AW-1:0]] = val;
   endtask

   task automatic seq_read(logic [7:0] idx, string req);
      logic [7:0] s, d;
      wait_ibf(); host_write(A_CTL, 8'h80);
      wait_ibf(); host_write(A_DATA, idx);
      wait_ibf();
      get_status(s);
      chk({req, " R5 obf set"}, s & 8'hF5, 8'h01);
      host_read(A_DATA, d);
      chk({req, " R5 data"}, d, shadow[idx[AW-1:0]]);
      get_status(s);
      chk({req, " R6 obf cleared"}, s[0], 0);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] s, d;
      int n, r0, w0;
      void'($urandom(32'd4711));
      for (int i = 0; i < (1<<AW); i++) begin
         regfile[i] = init_val(i);
         shadow[i]  = init_val(i);
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      get_status(s);
      chk("R1 status", s, 0);
      host_addr = A_DATA; #1;
      chk("R1 data", host_rdata, 0);
      chk("R1 strobes", {reg_rd, reg_wr}, 0);

      // R3/R4 busy window and command flag
      host_write(A_CTL, 8'h81);
      get_status(s);
      chk("R3 ibf set / R4 cmd flag / R2 zero bits", s, 8'h0A);
      n = 0;
      while (s[1] && n < 50) begin
         @(posedge clk); #1; n++;
         get_status(s);
      end
      chk("R3 busy length", n, DLY);
      host_write(A_DATA, 8'h05);
      get_status(s);
      chk("R4 cmd flag clear", s[3], 0);
      wait_ibf(); host_write(A_DATA, 8'hC3);
      wait_ibf(); shadow[5] = 8'hC3;
      seq_read(8'h05, "R7 write then");

      // R3 write during busy dropped
      wait_ibf(); host_write(A_CTL, 8'h80);
      host_write(A_DATA, 8'h09);
      get_status(s);
      chk("R3 dropped keeps cmd flag", s[3], 1);
      wait_ibf(); host_write(A_DATA, 8'h02);
      wait_ibf();
      host_read(A_DATA, d);
      chk("R3 dropped byte not used as index", d, shadow[2]);

      // R6 status read keeps obf
      wait_ibf(); host_write(A_CTL, 8'h80);
      wait_ibf(); host_write(A_DATA, 8'h07);
      wait_ibf();
      host_read(A_CTL, s);
      host_read(A_CTL, s);
      chk("R6 obf survives status read", s[0], 1);
      host_read(A_DATA, d);
      chk("R6 data", d, shadow[7]);

      // R8 stray data
      r0 = rd_cnt; w0 = wr_cnt;
      wait_ibf(); host_write(A_DATA, 8'h11);
      wait_ibf(); host_write(A_DATA, 8'h22);
      wait_ibf();
      chk("R8 no strobe", (rd_cnt - r0) + (wr_cnt - w0), 0);

      // R9 abort
      r0 = rd_cnt; w0 = wr_cnt;
      wait_ibf(); host_write(A_CTL, 8'h81);
      wait_ibf(); host_write(A_DATA, 8'h03);
      seq_read(8'h03, "R9 abort");
      chk("R9 no write", wr_cnt - w0, 0);
      chk("R9 one read", rd_cnt - r0, 1);

      // R10 unknown command
      r0 = rd_cnt; w0 = wr_cnt;
      wait_ibf(); host_write(A_CTL, 8'h80);
      wait_ibf(); host_write(A_CTL, 8'h42);
      wait_ibf(); host_write(A_DATA, 8'h01);
      wait_ibf(); host_write(A_DATA, 8'h99);
      wait_ibf();
      chk("R10 no strobe", (rd_cnt - r0) + (wr_cnt - w0), 0);
      seq_read(8'h01, "R10 regs intact");

      // random mix, R5 R7
      for (int k = 0; k < 60; k++) begin
         logic [7:0] idx, val;
         idx = 8'($urandom_range(0, (1<<AW) - 1));
         val = 8'($urandom);
         if ($urandom_range(0, 1) == 1) seq_write(idx, val);
         else seq_read(idx, "R5 random");
      end
      for (int i = 0; i < (1<<AW); i++)
         chk("R7 final contents", regfile[i], shadow[i]);

      chk("R11 exclusive strobes", both_cnt, 0);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule